// File: doc/BRIEF.md
# Streaming Internet Checksum Instruction Unit

This unit sits beside a processor as a multi-cycle custom instruction and computes the 16-bit ones' complement checksum used by IP, TCP and UDP. Software issues the instruction once per 16-bit word of a block, with the word in the low half of the operand and a final-word flag just above it. Every issue is qualified by a start strobe, and each accepted word is added into a 32-bit running sum.

A word without the final flag is acknowledged one cycle later, and the low half of the running sum comes back as the result. The processor is therefore never held up while it streams a block. When the word carries the final flag, the unit folds the upper half of the sum into the lower half until no carry remains. It then inverts the outcome and raises done for one cycle with the checksum in the low 16 bits of the result. The number of fold steps, and so the latency of the final issue, depends on the data. In that same cycle the sum is cleared for the next block.

A clock enable gates the whole unit: while it is low, nothing is accepted and every register holds its value. The reset is asynchronous and active low, and its release is synchronised inside the unit.

Top module: `csum_ci`

## Requirements
- R1: A word is taken only on a clock edge where both start and clk_en are high. The word is dataa[15:0], and dataa[31:17] never affect any output.
- R2: For an accepted word with dataa[16]=0, done is high after that edge and result[15:0] equals the low 16 bits of the 32-bit sum of all words accepted since the last final word.
- R3: For an accepted word with dataa[16]=1, the checksum presented is the bitwise inverse of the sum after its upper 16 bits have been repeatedly added into its lower 16 bits until the upper 16 bits are zero.
- R4: For a final word, done rises after 1 + F enabled clock edges, where F is the number of fold steps R3 needs (0 to 2). done stays high for one enabled cycle unless a new word is accepted.
- R5: After the final done, the sum is zero, so the next block's checksum depends only on its own words.
- R6: A start strobe that arrives while the unit is folding a final word is ignored.
- R7: While clk_en is low, done, result and the sum hold their values and a start strobe is ignored.
- R8: result[31:16] is always zero.
- R9: During and right after reset, done is 0 and result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en | input | 1 | Clock enable; when low all state holds |
| start | input | 1 | Issue strobe qualifying dataa |
| dataa | input | 32 | [15:0] data word, [16] final-word flag, [31:17] ignored |
| done | output | 1 | Result valid strobe |
| result | output | 32 | [15:0] partial sum or checksum, [31:16] zero |

## Verification
Two functions can fall in the same cycle: a fold step (or the finishing clear) of a final word, and the arrival of a fresh start strobe from the processor. The bench provokes this by driving start with a non-final word in the first busy cycle after a final word, both in directed packets and at random. It judges the outcome at the ports. The latency of the final done must still be exactly 1 + F cycles, and the checksum of the following block must come out as if the stray word had never been sent. The clock enable is also dropped, with start high, both mid-fold and between words, so that a hold and an issue meet in one cycle.

// File: rtl/csum_pkg.sv
package csum_pkg;
  // Control phases of the checksum unit
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,  // accepting words
    ST_FOLD = 1'b1   // folding carries of a finished block
  } csum_st_e;
endpackage

// File: rtl/csum_rst_sync.sv
module csum_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/csum_fold.sv
module csum_fold #(
  parameter int ACC_W  = 32,
  parameter int WORD_W = 16
) (
  input  logic [ACC_W-1:0] acc,
  output logic [ACC_W-1:0] folded,
  output logic             carry_free
);
  localparam int HI_W = ACC_W - WORD_W;

  logic [HI_W-1:0]   hi_part;
  logic [WORD_W-1:0] lo_part;

  always_comb begin
    hi_part    = acc[ACC_W-1:WORD_W];
    lo_part    = acc[WORD_W-1:0];
    folded     = ACC_W'(hi_part) + ACC_W'(lo_part);
    carry_free = (hi_part == '0);
  end
endmodule

// File: rtl/csum_acc.sv
module csum_acc #(
  parameter int ACC_W  = 32,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              add_en,
  input  logic              fold_en,
  input  logic              clr_en,
  input  logic [WORD_W-1:0] word,
  input  logic [ACC_W-1:0]  folded,
  output logic [ACC_W-1:0]  add_sum,
  output logic [ACC_W-1:0]  acc_q
);
  logic [ACC_W-1:0] acc_d;

  always_comb begin
    add_sum = acc_q + ACC_W'(word);
    acc_d   = acc_q;
    if (clr_en)       acc_d = '0;
    else if (fold_en) acc_d = folded;
    else if (add_en)  acc_d = add_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_d;
  end
endmodule

// File: rtl/csum_ctrl.sv
module csum_ctrl
  import csum_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  input  logic last,
  input  logic carry_free,
  output logic add_en,
  output logic fold_en,
  output logic clr_en,
  output logic partial,
  output logic finish,
  output logic busy
);
  csum_st_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    add_en  = 1'b0;
    fold_en = 1'b0;
    clr_en  = 1'b0;
    partial = 1'b0;
    finish  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          add_en = 1'b1;
          if (last) st_d    = ST_FOLD;
          else      partial = 1'b1;
        end
      end
      ST_FOLD: begin
        if (carry_free) begin
          clr_en = 1'b1;
          finish = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          fold_en = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  st_q <= ST_IDLE;
    else if (en) st_q <= st_d;
  end

  assign busy = (st_q == ST_FOLD);
endmodule

// File: rtl/csum_ci.sv
module csum_ci #(
  parameter int DATA_W      = 32,
  parameter int WORD_W      = 16,
  parameter int ACC_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              start,
  input  logic [DATA_W-1:0] dataa,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  localparam int LAST_BIT = WORD_W;

  logic              rst_sync_n;
  logic [WORD_W-1:0] word;
  logic              last;
  logic              add_en, fold_en, clr_en, partial, finish, busy;
  logic [ACC_W-1:0]  acc_q, add_sum, folded;
  logic              carry_free;
  logic              done_q, done_d;
  logic [WORD_W-1:0] res_q, res_d;
  logic              unused_hi;

  assign word      = dataa[WORD_W-1:0];
  assign last      = dataa[LAST_BIT];
  assign unused_hi = ^dataa[DATA_W-1:LAST_BIT+1];

  csum_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  csum_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .en         (clk_en),
    .start      (start),
    .last       (last),
    .carry_free (carry_free),
    .add_en     (add_en),
    .fold_en    (fold_en),
    .clr_en     (clr_en),
    .partial    (partial),
    .finish     (finish),
    .busy       (busy)
  );

  csum_fold #(.ACC_W(ACC_W), .WORD_W(WORD_W)) u_fold (
    .acc        (acc_q),
    .folded     (folded),
    .carry_free (carry_free)
  );

  csum_acc #(.ACC_W(ACC_W), .WORD_W(WORD_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en      (clk_en),
    .add_en  (add_en),
    .fold_en (fold_en),
    .clr_en  (clr_en),
    .word    (word),
    .folded  (folded),
    .add_sum (add_sum),
    .acc_q   (acc_q)
  );

  // Result and handshake: next-state logic
  always_comb begin
    done_d = partial | finish;
    res_d  = res_q;
    if (partial)     res_d = add_sum[WORD_W-1:0];
    else if (finish) res_d = ~acc_q[WORD_W-1:0];
  end

  // Result and handshake: registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done_q <= 1'b0;
      res_q  <= '0;
    end else if (clk_en) begin
      done_q <= done_d;
      res_q  <= res_d;
    end
  end

  assign done   = done_q;
  assign result = DATA_W'(res_q);
endmodule

// File: rtl/csum_ci_chk.sv
module csum_ci_chk #(
  parameter int DATA_W = 32,
  parameter int WORD_W = 16,
  parameter int ACC_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              start,
  input logic [DATA_W-1:0] dataa,
  input logic              done,
  input logic [DATA_W-1:0] result,
  input logic              busy,
  input logic [ACC_W-1:0]  acc,
  input logic              carry_free
);
  // R8: upper half of result is zero
  p_hi_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    result[DATA_W-1:WORD_W] == '0);

  // R2: non-final word is acknowledged on the next cycle
  p_partial_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && start && !dataa[WORD_W] && !busy) |=> done);

  // R2: partial result is the running sum low half
  p_partial_val_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && start && !dataa[WORD_W] && !busy) |=>
      (result[WORD_W-1:0] == $past(acc[WORD_W-1:0] + dataa[WORD_W-1:0])));

  // R3: final checksum is the inverted carry-free sum
  p_checksum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && clk_en && carry_free) |=>
      (done && (result[WORD_W-1:0] == ~$past(acc[WORD_W-1:0]))));

  // R5: finishing leaves the sum clear and the unit idle
  p_finish_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && clk_en && carry_free) |=> (!busy && acc == '0));

  // R6: while folding, done stays low and the unit stays busy
  p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && clk_en && !carry_free) |=> (busy && !done));

  // R7: clock enable low holds every output and the sum
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(done) && $stable(result) && $stable(acc) && $stable(busy)));

  // R1: done only rises after an enabled issue or a fold phase
  p_rise_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(clk_en && (start || busy)));
endmodule

bind csum_ci csum_ci_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W), .ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .clk_en     (clk_en),
  .start      (start),
  .dataa      (dataa),
  .done       (done),
  .result     (result),
  .busy       (busy),
  .acc        (acc_q),
  .carry_free (carry_free)
);

// File: tb/csum_ci_bench.sv
module csum_ci_bench;
  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic        clk_en;
  logic        start;
  logic [31:0] dataa;
  logic        done;
  logic [31:0] result;

  int total;
  int bad;
  logic [31:0] model_sum;

  csum_ci u_csum_ci (
    .clk    (clk),
    .rst_n  (rst_n),
    .clk_en (clk_en),
    .start  (start),
    .dataa  (dataa),
    .done   (done),
    .result (result)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int fold_steps(input logic [31:0] s);
    int n = 0;
    while (s[31:16] != 16'h0) begin
      s = {16'h0, s[31:16]} + {16'h0, s[15:0]};
      n++;
    end
    return n;
  endfunction

  function automatic logic [15:0] ck_of(input logic [31:0] s);
    while (s[31:16] != 16'h0) s = {16'h0, s[31:16]} + {16'h0, s[15:0]};
    return ~s[15:0];
  endfunction

  // Non-final word; R1 upper bits carry noise, R2 checked after the edge
  task automatic send_word(input logic [15:0] w, input logic [14:0] noise);
    @(negedge clk);
    clk_en = 1'b1; start = 1'b1; dataa = {noise, 1'b0, w};
    @(negedge clk);
    start = 1'b0; dataa = 32'h0;
    model_sum = model_sum + {16'h0, w};
    chk("R2 done", {31'h0, done}, 32'h1);
    chk("R2 partial", result, {16'h0, model_sum[15:0]});
    chk("R8 high half", {16'h0, result[31:16]}, 32'h0);
  endtask

  // Final word, with optional enable hold and a stray start in the busy cycle
  task automatic send_last(input logic [15:0] w, input logic [14:0] noise,
                           input int hold, input bit inject);
    logic [31:0] s;
    logic [31:0] held;
    int exp_lat;
    int lat;
    @(negedge clk);
    clk_en = 1'b1; start = 1'b1; dataa = {noise, 1'b1, w};
    @(negedge clk);
    start = 1'b0; dataa = 32'h0;
    s = model_sum + {16'h0, w};
    exp_lat = 1 + fold_steps(s);
    chk("R4 no early done", {31'h0, done}, 32'h0);
    if (hold > 0) begin
      held = result;
      clk_en = 1'b0;
      start = 1'b1; dataa = 32'h0000_2222;
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk("R7 done held", {31'h0, done}, 32'h0);
        chk("R7 result held", result, held);
      end
      start = 1'b0; dataa = 32'h0;
      clk_en = 1'b1;
    end
    if (inject) begin
      start = 1'b1; dataa = {15'h0, 1'b0, 16'h5A5A};
    end
    lat = 0;
    do begin
      @(negedge clk);
      start = 1'b0; dataa = 32'h0;
      lat++;
    end while (!done && lat < 8);
    chk("R4 latency", lat, exp_lat);
    chk("R3 checksum", result, {16'h0, ck_of(s)});
    model_sum = 32'h0;
    @(negedge clk);
    chk("R4 single pulse", {31'h0, done}, 32'h0);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'h1F0C_A5E3));
    total = 0; bad = 0; model_sum = 32'h0;
    rst_n = 1'b0; clk_en = 1'b0; start = 1'b0; dataa = 32'h0;
    repeat (3) @(negedge clk);
    chk("R9 done in reset", {31'h0, done}, 32'h0);
    chk("R9 result in reset", result, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 done after reset", {31'h0, done}, 32'h0);
    chk("R9 result after reset", result, 32'h0);

    // R3: zero block gives all ones, one-word all-ones block gives zero
    send_last(16'h0000, 15'h0, 0, 1'b0);
    chk("R3 zero block", result, 32'h0000_FFFF);
    send_last(16'hFFFF, 15'h7FFF, 0, 1'b0);
    chk("R3 ones block", result, 32'h0);

    // R3/R4: header-like block, one fold
    send_word(16'h4500, 15'h0); send_word(16'h0073, 15'h0);
    send_word(16'h0000, 15'h0); send_word(16'h4000, 15'h0);
    send_word(16'h4011, 15'h0); send_word(16'h0000, 15'h0);
    send_word(16'hC0A8, 15'h0); send_word(16'h0001, 15'h0);
    send_word(16'hC0A8, 15'h0);
    send_last(16'h00C7, 15'h0, 0, 1'b0);
    chk("R3 header", result, 32'h0000_B861);

    // R4: two folds needed (sum 0x1FFFF), stray start while busy (R6)
    send_word(16'hFFFF, 15'h0); send_word(16'hFFFF, 15'h0);
    send_last(16'h0001, 15'h0, 0, 1'b1);
    chk("R4 double fold", result, 32'h0000_FFFE);
    // R5/R6: next block excludes stray word and old sum
    send_last(16'h0001, 15'h0, 0, 1'b0);
    chk("R5 cleared", result, 32'h0000_FFFE);

    // R7: start with enable low between words is ignored
    send_word(16'h1000, 15'h1234);
    held = result;
    clk_en = 1'b0; start = 1'b1; dataa = 32'h0000_7777;
    repeat (3) begin
      @(negedge clk);
      chk("R7 idle hold done", {31'h0, done}, 32'h1);
      chk("R7 idle hold result", result, held);
    end
    start = 1'b0; clk_en = 1'b1; dataa = 32'h0;
    send_last(16'h0200, 15'h0, 3, 1'b0);
    chk("R7 ignored word", result, {16'h0, ~16'h1200});

    // Random blocks with noise, gaps, holds and stray starts
    for (int p = 0; p < 40; p++) begin
      int len = 1 + int'($urandom % 24);
      for (int k = 0; k < len; k++) begin
        logic [15:0] w = ($urandom % 3 == 0) ? 16'hFFFF : 16'($urandom);
        logic [14:0] nz = 15'($urandom);
        if ($urandom % 5 == 0) begin
          @(negedge clk);
          clk_en = 1'b0; start = 1'b1; dataa = $urandom;
          @(negedge clk);
          clk_en = 1'b1; start = 1'b0; dataa = 32'h0;
        end
        if (k == len - 1)
          send_last(w, nz, int'($urandom % 3), ($urandom % 3 == 0));
        else
          send_word(w, nz);
      end
    end
    finish_run();
  end
endmodule